// File: doc/BRIEF.md
# Linked-List DMA Descriptor Engine

This block is a single DMA channel that walks a chain of transfer descriptors stored in system memory. Software programs the running destination address and the pointer to the first descriptor, sets the global enable, and then writes the channel-enable bit. From then on the engine needs no attention. It reads each five-word descriptor through a single memory-master port and copies the described buffer one word at a time. When the buffer is done, it writes the updated control word back into the descriptor and follows the next pointer.

Each descriptor carries a destination field, but the engine discards it. Destination data keeps running on from where the previous buffer stopped. Only the first control word goes back to memory, with its remaining-size field at zero and its done flag set, so software can poll the descriptors themselves. A buffer event and an end-of-chain event are pulsed on ports and latched into a status register. Reading that register clears it, and the interrupt line is high while any latched bit is set.

Top module: `lldma_engine`

## Requirements
- R1: After reset the channel-enable bit reads 0, the status register reads 0, `irq` is low and `mem_req` is low.
- R2: The register port uses word offsets: 0 global enable (bit 0), 1 channel enable (bit 0), 2 destination address, 3 channel configuration, 4 descriptor pointer, 5 status, 6 source readback, 7 control-A readback, 8 control-B readback. A write of 1 to channel enable starts a chain only if global enable bit 0 is 1. Otherwise the write is ignored: channel enable reads 0 and no memory request is issued.
- R3: A descriptor occupies five consecutive words at byte offsets +0 source, +4 destination, +8 control A, +12 control B and +16 next pointer. Control A holds the buffer size in words in bits [15:0] and the done flag in bit 31. Control B bit 0 is the reload enable. After a chain, source readback equals the last source plus 4 times its size, control-B readback equals the last control B, and control-A readback has its size field at 0.
- R4: The destination field of every descriptor is ignored. Data lands at consecutive words from the programmed destination address across all buffers, and the destination register finally reads that start plus 4 times the total word count.
- R5: Each buffer copies its size in words from consecutive source words to consecutive destination words. A size of 0 moves nothing, and the word after the last destination word is left unchanged.
- R6: At the end of each buffer exactly one write goes to descriptor offset +8. Its value is the fetched control A with bit 31 set to 1 and bits [15:0] set to 0. The other four descriptor words are never written.
- R7: The engine goes on to the next descriptor without waiting for any status read. `buf_evt` pulses exactly once per buffer.
- R8: A buffer ends the chain only when the next pointer is 0 and control-B bit 0 is 0. A zero next pointer with reload set fetches the next descriptor from address 0. At chain end, `chain_evt` pulses once and channel enable clears itself.
- R9: Status bit 0 latches buffer events and bit 1 latches chain completion, and `irq` is the OR of both bits. A status read returns the latched bits and clears them.
- R10: While `mem_req` is high and `mem_ack` is low, the address, the write flag and the write data are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears status when addressing it) |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| buf_evt | output | 1 | One-cycle pulse per finished buffer |
| chain_evt | output | 1 | One-cycle pulse when the chain ends |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The properties assume that memory raises `mem_ack` only while `mem_req` is high and only once per request. They also assume that the destination, configuration and descriptor-pointer registers are written only while the channel is idle. The bench's memory responder acknowledges each request exactly once, after a random wait of zero or more cycles, and drops the acknowledge on the following cycle. The bench programs the channel only after it has seen the previous chain end. Random chains vary length, buffer sizes (zero included), reload bits and descriptor garbage. Directed runs cover the disabled start and a descriptor placed at address 0.

// File: rtl/lldma_engine.sv
module lldma_engine #(
  parameter int SZ_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        buf_evt,
  output logic        chain_evt,
  output logic        irq
);
  localparam logic [3:0] A_GEN = 4'd0, A_CHEN = 4'd1, A_DST = 4'd2, A_CFG = 4'd3,
                         A_DESC = 4'd4, A_STAT = 4'd5, A_SRC = 4'd6, A_CTLA = 4'd7,
                         A_CTLB = 4'd8;
  localparam int LAST_IDX = 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_WB} st_t;

  st_t         st;
  logic        gen_en, chen;
  logic [31:0] dst, cfg, nxt, src, ctla, ctlb, cur, buf_q;
  logic [2:0]  idx;
  logic [1:0]  stat;

  wire [SZ_W-1:0] size    = ctla[SZ_W-1:0];
  wire            is_last = (nxt == 32'd0) && !ctlb[0];
  wire            start   = reg_we && reg_addr == A_CHEN && reg_wdata[0] && gen_en && !chen;
  wire            stat_rd = reg_re && reg_addr == A_STAT;

  assign mem_req   = st != S_IDLE;
  assign mem_we    = st == S_WR || st == S_WB;
  assign mem_wdata = (st == S_WB) ? {1'b1, ctla[30:0]} : buf_q;
  assign buf_evt   = st == S_WB && mem_ack;
  assign chain_evt = buf_evt && is_last;
  assign irq       = |stat;

  always_comb begin
    case (st)
      S_FETCH: mem_addr = cur + {27'd0, idx, 2'b00};
      S_RD:    mem_addr = src;
      S_WR:    mem_addr = dst;
      S_WB:    mem_addr = cur + 32'd8;
      default: mem_addr = 32'd0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_GEN:   reg_rdata = {31'd0, gen_en};
      A_CHEN:  reg_rdata = {31'd0, chen};
      A_DST:   reg_rdata = dst;
      A_CFG:   reg_rdata = cfg;
      A_DESC:  reg_rdata = nxt;
      A_STAT:  reg_rdata = {30'd0, stat};
      A_SRC:   reg_rdata = src;
      A_CTLA:  reg_rdata = ctla;
      A_CTLB:  reg_rdata = ctlb;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      gen_en <= 1'b0;
      chen   <= 1'b0;
      dst    <= '0;
      cfg    <= '0;
      nxt    <= '0;
      src    <= '0;
      ctla   <= '0;
      ctlb   <= '0;
      cur    <= '0;
      buf_q  <= '0;
      idx    <= '0;
      stat   <= '0;
    end else begin
      if (reg_we && reg_addr == A_GEN) gen_en <= reg_wdata[0];
      if (reg_we && !chen) begin
        case (reg_addr)
          A_DST:   dst <= reg_wdata;
          A_CFG:   cfg <= reg_wdata;
          A_DESC:  nxt <= reg_wdata;
          default: ;
        endcase
      end
      stat <= (stat_rd ? 2'b00 : stat) | {chain_evt, buf_evt};

      case (st)
        S_IDLE: if (start) begin
          chen <= 1'b1;
          cur  <= nxt;
          idx  <= '0;
          st   <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (idx)
            3'd0:    src  <= mem_rdata;
            3'd2:    ctla <= mem_rdata;
            3'd3:    ctlb <= mem_rdata;
            3'd4:    nxt  <= mem_rdata;
            default: ;
          endcase
          if (idx == 3'(LAST_IDX)) st <= (size == '0) ? S_WB : S_RD;
          else idx <= idx + 3'd1;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st    <= S_WR;
        end
        S_WR: if (mem_ack) begin
          src             <= src + 32'd4;
          dst             <= dst + 32'd4;
          ctla[SZ_W-1:0]  <= size - SZ_W'(1);
          st              <= (size == SZ_W'(1)) ? S_WB : S_RD;
        end
        S_WB: if (mem_ack) begin
          if (is_last) begin
            chen <= 1'b0;
            st   <= S_IDLE;
          end else begin
            cur <= nxt;
            idx <= '0;
            st  <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module lldma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        buf_evt,
  input logic        chain_evt,
  input logic        irq,
  input logic        reg_re,
  input logic [3:0]  reg_addr,
  input logic        chen,
  input logic        gen_en
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R6
  wb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_evt |-> mem_we && mem_wdata[31] && mem_wdata[15:0] == 16'd0);
  // R8
  chain_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_evt |-> buf_evt);
  // R8
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_evt |=> !chen);
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chen) |-> $past(gen_en));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chen |-> !mem_req);
  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && reg_addr == 4'd5 && !buf_evt |=> !irq);
endmodule

bind lldma_engine lldma_engine_chk i_lldma_engine_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .buf_evt(buf_evt), .chain_evt(chain_evt),
  .irq(irq), .reg_re(reg_re), .reg_addr(reg_addr), .chen(chen), .gen_en(gen_en)
);

// File: tb/test_lldma_engine.sv
`timescale 1ns/1ps
module test_lldma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        buf_evt, chain_evt, irq;

  lldma_engine i_lldma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_evt(buf_evt), .chain_evt(chain_evt), .irq(irq)
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:1023];
  int total = 0, bad = 0;
  int buf_cnt = 0, chain_cnt = 0, req_cycles = 0;
  logic [31:0] d_addr [0:3], d_src [0:3], d_ca [0:3], d_cb [0:3], d_nx [0:3], d_dst [0:3];
  int          d_size [0:3];

  function automatic logic [31:0] init_word(int i);
    return 32'hDEAD0000 | i;
  endfunction

  function automatic logic [31:0] wb_word(logic [31:0] ca);
    return {1'b1, ca[30:16], 16'h0000};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && ($urandom % 3) != 0) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (buf_evt) buf_cnt++;
      if (chain_evt) chain_cnt++;
      if (mem_req) req_cycles++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  task automatic run_chain(int n, logic [31:0] dst0);
    logic [31:0] v;
    int wbase, t, c0, b0, waited;
    for (int i = 0; i < 1024; i++) mem[i] = init_word(i);
    for (int k = 0; k < 4; k++) d_src[k] = 32'h400 + 32'h40 * k;
    for (int k = 0; k < n; k++) begin
      d_size[k] = $urandom_range(0, 6);
      d_ca[k]   = {$urandom} & 32'hFFFF0000 | d_size[k];
      d_dst[k]  = $urandom;
      if (k < n - 1) begin
        d_nx[k] = d_addr[k + 1];
        d_cb[k] = {$urandom} & 32'hFFFFFFFE | ((d_nx[k] == 0) ? 32'd1 : {31'd0, 1'($urandom)});
      end else begin
        d_nx[k] = 32'd0;
        d_cb[k] = {$urandom} & 32'hFFFFFFFE;
      end
      for (int j = 0; j < d_size[k]; j++) mem[(d_src[k] >> 2) + j] = $urandom;
      mem[(d_addr[k] >> 2) + 0] = d_src[k];
      mem[(d_addr[k] >> 2) + 1] = d_dst[k];
      mem[(d_addr[k] >> 2) + 2] = d_ca[k];
      mem[(d_addr[k] >> 2) + 3] = d_cb[k];
      mem[(d_addr[k] >> 2) + 4] = d_nx[k];
    end
    wr(4'd2, dst0);
    wr(4'd4, d_addr[0]);
    c0 = chain_cnt; b0 = buf_cnt;
    wr(4'd1, 32'd1);
    waited = 0;
    while (chain_cnt == c0 && waited < 5000) begin @(negedge clk); waited++; end
    repeat (3) @(negedge clk);
    chk("R8 chain completed once", 32'(chain_cnt - c0), 32'd1);
    chk("R7 one buffer event per descriptor", 32'(buf_cnt - b0), 32'(n));
    rd(4'd1, v); chk("R8 channel enable self-cleared", v, 32'd0);
    wbase = dst0 >> 2; t = 0;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < d_size[k]; j++) begin
        chk("R5 R4 destination word", mem[wbase + t], mem[(d_src[k] >> 2) + j]);
        t++;
      end
    chk("R5 word past end untouched", mem[wbase + t], init_word(wbase + t));
    rd(4'd2, v); chk("R4 destination register runs on", v, dst0 + 32'(4 * t));
    for (int k = 0; k < n; k++) begin
      chk("R6 control A written back", mem[(d_addr[k] >> 2) + 2], wb_word(d_ca[k]));
      chk("R6 source word untouched", mem[(d_addr[k] >> 2) + 0], d_src[k]);
      chk("R6 R4 destination field untouched", mem[(d_addr[k] >> 2) + 1], d_dst[k]);
      chk("R6 control B untouched", mem[(d_addr[k] >> 2) + 3], d_cb[k]);
      chk("R6 next pointer untouched", mem[(d_addr[k] >> 2) + 4], d_nx[k]);
    end
    rd(4'd6, v); chk("R3 source readback", v, d_src[n - 1] + 32'(4 * d_size[n - 1]));
    rd(4'd8, v); chk("R3 control B readback", v, d_cb[n - 1]);
    rd(4'd7, v); chk("R3 control A readback", v, {d_ca[n - 1][31:16], 16'h0000});
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    rd(4'd5, v); chk("R9 status latched both events", v, 32'd3);
    rd(4'd5, v); chk("R9 status cleared by read", v, 32'd0);
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int rq;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = init_word(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req low after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 irq low after reset", {31'd0, irq}, 32'd0);
    rd(4'd1, v); chk("R1 channel enable reset", v, 32'd0);
    rd(4'd5, v); chk("R1 status reset", v, 32'd0);

    wr(4'd4, 32'h100);
    wr(4'd3, 32'hC0FFEE01);
    rd(4'd3, v); chk("R2 configuration readback", v, 32'hC0FFEE01);
    rq = req_cycles;
    wr(4'd1, 32'd1);
    repeat (10) @(negedge clk);
    rd(4'd1, v); chk("R2 start ignored while globally disabled", v, 32'd0);
    chk("R2 no memory request while disabled", 32'(req_cycles - rq), 32'd0);
    wr(4'd0, 32'd1);
    rd(4'd0, v); chk("R2 global enable readback", v, 32'd1);

    for (int r = 0; r < 8; r++) begin
      int n = $urandom_range(1, 4);
      for (int k = 0; k < 4; k++) d_addr[k] = 32'h100 + 32'h20 * k;
      run_chain(n, 32'h800 + 32'(4 * $urandom_range(0, 7)));
    end

    d_addr[0] = 32'h180;
    d_addr[1] = 32'h000;
    run_chain(2, 32'h900);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule